// File: doc/BRIEF.md
# Center-Aligned PWM Channel with Buffered Compare

This block is one channel of a motor-drive PWM. An internal counter ramps from zero up to a programmed period value and back down again, so each output pulse is centred on the counter's zero point. A high-side output follows compare A. A complementary low-side output is held off for a programmable number of clocks after every high-side turn-off. A second compare value, B, raises a one-clock conversion-start pulse for an external ADC. That pulse fires on a match while the counter rises or while it falls, as selected.

Both compare values can be buffered. In buffered mode a write is held in a pending register and reaches the active register only when the counter is at zero, so a pulse never sees a half-applied update. In direct mode a write reaches the active register on the next clock. Two read ports show compare A: the pending value last written, and a mirror of the value the comparator is using. Firmware can use them together to place the next conversion point.

Four small state machines make up the block. The counter direction machine has states `DIR_UP` and `DIR_DOWN`. Its transition `turn_down` is taken when the count is at or above the period during `DIR_UP`. Its transition `turn_up` is taken when the count is zero during `DIR_DOWN`. The output machine has states `OUT_GAP` (both sides off), `OUT_HIGH` and `OUT_LOW`. Its transitions are `hi_off_gap` (HIGH to GAP when compare fails and the dead-band is non-zero), `hi_off_direct` (HIGH to LOW when the dead-band is zero), `gap_done` (GAP to LOW once the gap count reaches the dead-band), `gap_abort` (GAP to HIGH) and `lo_off` (LOW to HIGH). The trigger machine has states `SOC_ARMED` and `SOC_SPENT`. Its transition `fire` goes from ARMED to SPENT on a qualifying match, and `rearm` returns to ARMED at the period wrap. Each compare buffer has one load path, selected by mode rather than by state.

Top module: `cpwm_channel`

## Requirements
- R1: After reset the internal count starts at 0 and rising. It steps by one each clock up to the period value P (P >= 1), then back down to 0. Zero and P each last exactly one clock, so one full period is 2*P clocks and `pwm_hi_o` rises once every 2*P clocks.
- R2: `pwm_hi_o` is registered. In each clock it shows whether the count in the previous clock was strictly below the active compare A. The same rule applies rising and falling, so for 1 <= A <= P the high time per period is 2*A-1 clocks.
- R3: With `shadow_en_i`=1, a write to compare A changes only the pending register. The active register takes the pending value (as held before that clock) at each clock where the count is 0, and at no other time.
- R4: With `shadow_en_i`=0, a write to compare A sets the active register on the same clock edge that captures it.
- R5: `cmpa_pend_o` returns the last value written to compare A, one clock after the write. `cmpa_mirror_o` returns the active compare A.
- R6: Compare B follows the same buffering rules as compare A under the same `shadow_en_i`. A buffered write takes effect only at the next count of 0, and a direct write takes effect on the next clock.
- R7: `soc_o` is a registered one-clock pulse. It is asserted in the clock after one where the count equals active compare B and the direction matches `soc_down_sel_i` (1 = falling, 0 = rising).
- R8: `soc_o` fires at most once per period. A period runs from the clock after the falling count reaches 0 through the next such clock. A second match in the same period, after a direct rewrite of compare B, is ignored.
- R9: `pwm_hi_o` and `pwm_lo_o` are never both high. `pwm_lo_o` rises `fed_count_i` clocks after `pwm_hi_o` falls, or on the same edge when the count is 0. `pwm_lo_o` falls on the same edge on which `pwm_hi_o` rises.
- R10: While `rst_n` is low, `pwm_hi_o`, `pwm_lo_o` and `soc_o` are 0 and both compare read-backs are 0.
- R11: An active compare A of 0 keeps `pwm_hi_o` low for the whole period. An active compare A above P keeps it high for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_i | input | CW | Counter turn-around value P |
| cmpa_wr_i | input | 1 | Write strobe for compare A |
| cmpa_wdata_i | input | CW | Compare A write data |
| cmpb_wr_i | input | 1 | Write strobe for compare B |
| cmpb_wdata_i | input | CW | Compare B write data |
| shadow_en_i | input | 1 | 1 = buffered loads at count zero, 0 = direct loads |
| soc_down_sel_i | input | 1 | 1 = trigger on falling match, 0 = on rising match |
| fed_count_i | input | DBW | Clocks between high-side turn-off and low-side turn-on |
| pwm_hi_o | output | 1 | High-side drive |
| pwm_lo_o | output | 1 | Low-side drive |
| soc_o | output | 1 | Conversion-start pulse |
| cmpa_pend_o | output | CW | Last written compare A |
| cmpa_mirror_o | output | CW | Active compare A |

## Verification
The main function is driven with compare A at a mid value, at zero and above the period. The pulse width, the centring of the pulse and the two saturated cases are each told apart by a cycle-accurate expectation. Compare writes are placed mid-rise in both buffered and direct mode. The written value is chosen so that an early or late load would move or suppress a conversion pulse, and so that the mirror and pending read-backs differ. A direct rewrite of compare B after the pulse has already fired separates the once-per-period guard from plain matching. Non-zero and changed dead-band counts show the low-side delay against the high-side fall.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    typedef enum logic [1:0] {
        OUT_GAP  = 2'd0,
        OUT_HIGH = 2'd1,
        OUT_LOW  = 2'd2
    } out_state_e;

    typedef enum logic {
        SOC_ARMED = 1'b0,
        SOC_SPENT = 1'b1
    } soc_state_e;

endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period_i,
    output logic [CW-1:0] cnt_o,
    output logic          dir_down_o,
    output logic          at_zero_o,
    output logic          wrap_o
);
    import cpwm_pkg::*;

    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] ZERO = '0;

    cnt_dir_e      state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next-state and next-count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DIR_UP: begin
                if (cnt_q >= period_i) begin
                    state_d = DIR_DOWN;                       // turn_down
                    cnt_d   = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            DIR_DOWN: begin
                if (cnt_q == ZERO) begin
                    state_d = DIR_UP;                         // turn_up
                    cnt_d   = (period_i == ZERO) ? ZERO : ONE;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            default: begin
                state_d = DIR_UP;
                cnt_d   = ZERO;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIR_UP;
            cnt_q   <= ZERO;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        cnt_o      = cnt_q;
        dir_down_o = (state_q == DIR_DOWN);
        at_zero_o  = (cnt_q == ZERO);
        wrap_o     = (state_q == DIR_DOWN) && (cnt_q == ZERO);
    end

endmodule

// File: rtl/cpwm_cmp_shadow.sv
module cpwm_cmp_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         shadow_en_i,
    input  logic         load_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] act_o
);
    logic [W-1:0] pend_q;
    logic [W-1:0] act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (wr_i) begin
            pend_q <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (!shadow_en_i && wr_i) begin
            act_q <= wdata_i;
        end else if (shadow_en_i && load_i) begin
            act_q <= pend_q;
        end
    end

    assign pend_o = pend_q;
    assign act_o  = act_q;

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
    parameter int DBW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           raw_i,
    input  logic [DBW-1:0] fed_i,
    output logic           hi_o,
    output logic           lo_o
);
    import cpwm_pkg::*;

    localparam logic [DBW-1:0] GONE = DBW'(1);

    out_state_e     state_q, state_d;
    logic [DBW-1:0] gcnt_q, gcnt_d;

    always_comb begin
        state_d = state_q;
        gcnt_d  = gcnt_q;
        unique case (state_q)
            OUT_HIGH: begin
                if (!raw_i) begin
                    if (fed_i == '0) begin
                        state_d = OUT_LOW;                    // hi_off_direct
                    end else begin
                        state_d = OUT_GAP;                    // hi_off_gap
                        gcnt_d  = GONE;
                    end
                end
            end
            OUT_GAP: begin
                if (raw_i) begin
                    state_d = OUT_HIGH;                       // gap_abort
                end else if (gcnt_q >= fed_i) begin
                    state_d = OUT_LOW;                        // gap_done
                end else begin
                    gcnt_d = gcnt_q + GONE;
                end
            end
            OUT_LOW: begin
                if (raw_i) begin
                    state_d = OUT_HIGH;                       // lo_off
                end
            end
            default: begin
                state_d = OUT_GAP;
                gcnt_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_GAP;
            gcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            gcnt_q  <= gcnt_d;
        end
    end

    always_comb begin
        hi_o = (state_q == OUT_HIGH);
        lo_o = (state_q == OUT_LOW);
    end

endmodule

// File: rtl/cpwm_soc_gen.sv
module cpwm_soc_gen #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] cmpb_i,
    input  logic          dir_down_i,
    input  logic          wrap_i,
    input  logic          down_sel_i,
    output logic          soc_o
);
    import cpwm_pkg::*;

    soc_state_e state_q, state_d;
    logic       match;
    logic       fire;
    logic       soc_q;

    always_comb begin
        match = (cnt_i == cmpb_i) && (down_sel_i ? dir_down_i : !dir_down_i);
        fire  = match && (state_q == SOC_ARMED);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SOC_ARMED: begin
                if (wrap_i)    state_d = SOC_ARMED;
                else if (fire) state_d = SOC_SPENT;           // fire
            end
            SOC_SPENT: begin
                if (wrap_i)    state_d = SOC_ARMED;           // rearm
            end
            default:           state_d = SOC_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SOC_ARMED;
            soc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            soc_q   <= fire;
        end
    end

    assign soc_o = soc_q;

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel #(
    parameter int CW  = 16,
    parameter int DBW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  period_i,
    input  logic           cmpa_wr_i,
    input  logic [CW-1:0]  cmpa_wdata_i,
    input  logic           cmpb_wr_i,
    input  logic [CW-1:0]  cmpb_wdata_i,
    input  logic           shadow_en_i,
    input  logic           soc_down_sel_i,
    input  logic [DBW-1:0] fed_count_i,
    output logic           pwm_hi_o,
    output logic           pwm_lo_o,
    output logic           soc_o,
    output logic [CW-1:0]  cmpa_pend_o,
    output logic [CW-1:0]  cmpa_mirror_o
);
    localparam int NCMP = 2;

    logic [CW-1:0] cnt_w;
    logic          dir_down_w;
    logic          at_zero_w;
    logic          wrap_w;
    logic          raw_w;

    logic          cmp_wr   [NCMP];
    logic [CW-1:0] cmp_wd   [NCMP];
    logic [CW-1:0] cmp_pend [NCMP];
    logic [CW-1:0] cmp_act  [NCMP];

    assign cmp_wr[0] = cmpa_wr_i;
    assign cmp_wd[0] = cmpa_wdata_i;
    assign cmp_wr[1] = cmpb_wr_i;
    assign cmp_wd[1] = cmpb_wdata_i;

    cpwm_counter #(.CW(CW)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_i   (period_i),
        .cnt_o      (cnt_w),
        .dir_down_o (dir_down_w),
        .at_zero_o  (at_zero_w),
        .wrap_o     (wrap_w)
    );

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        cpwm_cmp_shadow #(.W(CW)) shd_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_i        (cmp_wr[g]),
            .wdata_i     (cmp_wd[g]),
            .shadow_en_i (shadow_en_i),
            .load_i      (at_zero_w),
            .pend_o      (cmp_pend[g]),
            .act_o       (cmp_act[g])
        );
    end

    assign raw_w = (cnt_w < cmp_act[0]);

    cpwm_deadband #(.DBW(DBW)) db_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw_w),
        .fed_i (fed_count_i),
        .hi_o  (pwm_hi_o),
        .lo_o  (pwm_lo_o)
    );

    cpwm_soc_gen #(.CW(CW)) soc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (cnt_w),
        .cmpb_i     (cmp_act[1]),
        .dir_down_i (dir_down_w),
        .wrap_i     (wrap_w),
        .down_sel_i (soc_down_sel_i),
        .soc_o      (soc_o)
    );

    assign cmpa_pend_o   = cmp_pend[0];
    assign cmpa_mirror_o = cmp_act[0];

endmodule

// File: rtl/cpwm_channel_chk.sv
module cpwm_channel_chk #(
    parameter int CW  = 16,
    parameter int DBW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [CW-1:0]  period_i,
    input logic           cmpa_wr_i,
    input logic [CW-1:0]  cmpa_wdata_i,
    input logic           shadow_en_i,
    input logic [DBW-1:0] fed_count_i,
    input logic           pwm_hi_o,
    input logic           pwm_lo_o,
    input logic           soc_o,
    input logic [CW-1:0]  cmpa_pend_o,
    input logic [CW-1:0]  cmpa_mirror_o,
    input logic [CW-1:0]  cnt_w
);
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i != '0) |=> ((cnt_w == $past(cnt_w) + CW'(1)) || (cnt_w == $past(cnt_w) - CW'(1))));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_en_i && (cnt_w != '0)) |=> $stable(cmpa_mirror_o));

    assert_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!shadow_en_i && cmpa_wr_i) |=> (cmpa_mirror_o == $past(cmpa_wdata_i)));

    assert_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmpa_wr_i |=> (cmpa_pend_o == $past(cmpa_wdata_i)));

    assert_one_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soc_o |=> !soc_o);

    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_hi_o && pwm_lo_o));

    assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwm_hi_o) && ($past(fed_count_i) != '0)) |-> !pwm_lo_o);

endmodule

bind cpwm_channel cpwm_channel_chk #(.CW(CW), .DBW(DBW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .period_i      (period_i),
    .cmpa_wr_i     (cmpa_wr_i),
    .cmpa_wdata_i  (cmpa_wdata_i),
    .shadow_en_i   (shadow_en_i),
    .fed_count_i   (fed_count_i),
    .pwm_hi_o      (pwm_hi_o),
    .pwm_lo_o      (pwm_lo_o),
    .soc_o         (soc_o),
    .cmpa_pend_o   (cmpa_pend_o),
    .cmpa_mirror_o (cmpa_mirror_o),
    .cnt_w         (cnt_w)
);

// File: tb/cpwm_channel_tb_top.sv
`timescale 1ns/1ps
module cpwm_channel_tb_top;

    localparam int CW  = 16;
    localparam int DBW = 8;
    localparam int P   = 10;

    typedef struct packed {
        logic          hi;
        logic          lo;
        logic          soc;
        logic [CW-1:0] act;
        logic [CW-1:0] pend;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [CW-1:0]  tb_period = CW'(P);
    logic           tb_wr_a = 1'b0;
    logic [CW-1:0]  tb_da = '0;
    logic           tb_wr_b = 1'b0;
    logic [CW-1:0]  tb_db = '0;
    logic           tb_shadow = 1'b1;
    logic           tb_sel = 1'b0;
    logic [DBW-1:0] tb_fed = '0;
    logic           pwm_hi, pwm_lo, soc;
    logic [CW-1:0]  pend_a, mirror_a;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    exp_t exp_q[$];

    // bench-side model of the requirements
    logic [CW-1:0] m_cnt = '0;
    logic          m_down = 1'b0;
    logic [CW-1:0] m_pend_a = '0, m_act_a = '0, m_pend_b = '0, m_act_b = '0;
    logic          m_fired = 1'b0;
    logic          m_hi = 1'b0, m_lo = 1'b0;
    int            m_lorun = 0;

    int hi_ones, lo_ones, soc_seen;

    always #2.5 clk = ~clk;

    cpwm_channel #(.CW(CW), .DBW(DBW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .period_i       (tb_period),
        .cmpa_wr_i      (tb_wr_a),
        .cmpa_wdata_i   (tb_da),
        .cmpb_wr_i      (tb_wr_b),
        .cmpb_wdata_i   (tb_db),
        .shadow_en_i    (tb_shadow),
        .soc_down_sel_i (tb_sel),
        .fed_count_i    (tb_fed),
        .pwm_hi_o       (pwm_hi),
        .pwm_lo_o       (pwm_lo),
        .soc_o          (soc),
        .cmpa_pend_o    (pend_a),
        .cmpa_mirror_o  (mirror_a)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int actual, input int expected);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    // driver: predicts the result of the next edge, pushes it, waits
    task automatic tick();
        exp_t          e;
        logic [CW-1:0] n_cnt;
        logic          n_down;
        logic          fire, wrap, zero;
        int            n_lorun;
        zero   = (m_cnt == '0);
        wrap   = m_down && zero;
        fire   = (m_cnt == m_act_b) && (tb_sel ? m_down : !m_down) && !m_fired;
        e.hi   = (m_cnt < m_act_a);
        n_lorun = e.hi ? 0 : m_lorun + 1;
        e.lo   = !e.hi && (m_lo || (n_lorun > int'(tb_fed)));
        e.soc  = fire;
        n_down = m_down;
        if (!m_down) begin
            if (m_cnt >= tb_period) begin
                n_down = 1'b1;
                n_cnt  = zero ? '0 : m_cnt - 1'b1;
            end else n_cnt = m_cnt + 1'b1;
        end else begin
            if (zero) begin
                n_down = 1'b0;
                n_cnt  = (tb_period == '0) ? '0 : CW'(1);
            end else n_cnt = m_cnt - 1'b1;
        end
        if (!tb_shadow && tb_wr_a) m_act_a = tb_da;
        else if (tb_shadow && zero) m_act_a = m_pend_a;
        if (!tb_shadow && tb_wr_b) m_act_b = tb_db;
        else if (tb_shadow && zero) m_act_b = m_pend_b;
        if (tb_wr_a) m_pend_a = tb_da;
        if (tb_wr_b) m_pend_b = tb_db;
        m_fired = wrap ? 1'b0 : (m_fired | fire);
        m_cnt   = n_cnt;
        m_down  = n_down;
        m_hi    = e.hi;
        m_lo    = e.lo;
        m_lorun = n_lorun;
        e.act   = m_act_a;
        e.pend  = m_pend_a;
        exp_q.push_back(e);
        @(negedge clk);
        tb_wr_a = 1'b0;
        tb_wr_b = 1'b0;
        if (pwm_hi) hi_ones++;
        if (pwm_lo) lo_ones++;
        if (soc)    soc_seen++;
    endtask

    task automatic clear_counts();
        hi_ones = 0; lo_ones = 0; soc_seen = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic run_until(input int v, input bit d);
        for (int i = 0; i < 4*P + 4; i++) begin
            tick();
            if (m_cnt == CW'(v) && m_down == d) break;
        end
    endtask

    // monitor: compares each predicted item just after its edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(pwm_hi == e.hi,   "R2", "pwm_hi", pwm_hi, e.hi);
                check(pwm_lo == e.lo,   "R9", "pwm_lo", pwm_lo, e.lo);
                check(soc == e.soc,     "R7", "soc", soc, e.soc);
                check(mirror_a == e.act, "R5", "mirror", mirror_a, e.act);
                check(pend_a == e.pend,  "R5", "pending", pend_a, e.pend);
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            check(1'b0, "watchdog", "timeout", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int gap;
        int per;
        clear_counts();
        repeat (3) @(negedge clk);
        // R10: reset state
        check(pwm_hi == 1'b0 && pwm_lo == 1'b0, "R10", "drives in reset", {pwm_hi, pwm_lo}, 0);
        check(soc == 1'b0, "R10", "soc in reset", soc, 0);
        check(mirror_a == '0 && pend_a == '0, "R10", "compare read-back", mirror_a + pend_a, 0);
        rst_n = 1'b1;

        // R3: buffered write reaches only the pending register
        tb_wr_a = 1'b1; tb_da = 16'd4;
        tb_wr_b = 1'b1; tb_db = 16'd3;
        tick();
        check(pend_a == 16'd4, "R3", "pending after write", pend_a, 4);
        check(mirror_a == 16'd0, "R3", "mirror before zero", mirror_a, 0);
        run_until(0, 1'b1);
        check(mirror_a == 16'd0, "R3", "mirror at last down zero", mirror_a, 0);
        tick();
        check(mirror_a == 16'd4, "R3", "mirror after zero", mirror_a, 4);

        // R1 / R2: high time and repetition
        clear_counts();
        run(2*P);
        check(hi_ones == 7, "R2", "high clocks per period A=4", hi_ones, 7);
        check(soc_seen == 1, "R7", "rising trigger per period", soc_seen, 1);
        per = 0;
        for (int i = 0; i < 4*P; i++) begin
            logic prev;
            prev = pwm_hi;
            tick();
            if (!prev && pwm_hi) break;
        end
        for (int i = 0; i < 4*P; i++) begin
            logic prev;
            prev = pwm_hi;
            tick();
            per++;
            if (!prev && pwm_hi) break;
        end
        check(per == 2*P, "R1", "clocks between high-side rises", per, 2*P);

        // R9: dead-band on the low-side turn-on
        tb_fed = 8'd3;
        for (int i = 0; i < 4*P; i++) begin
            logic prev;
            prev = pwm_hi;
            tick();
            if (prev && !pwm_hi) break;
        end
        check(pwm_lo == 1'b0, "R9", "low side off at high fall", pwm_lo, 0);
        gap = 0;
        for (int i = 0; i < 4*P; i++) begin
            tick();
            gap++;
            if (pwm_lo) break;
        end
        check(gap == 3, "R9", "clocks from high fall to low rise", gap, 3);

        // R7: falling-direction trigger
        tb_sel = 1'b1;
        run_until(0, 1'b1);
        clear_counts();
        run(2*P);
        check(soc_seen == 1, "R7", "falling trigger per period", soc_seen, 1);
        tb_sel = 1'b0;

        // R3: mid-period buffered rewrite of compare A
        run_until(5, 1'b0);
        tb_wr_a = 1'b1; tb_da = 16'd7;
        tick();
        check(pend_a == 16'd7 && mirror_a == 16'd4, "R3", "mirror holds mid period", mirror_a, 4);

        // R6: buffered compare B write waits for zero
        run_until(0, 1'b1);
        run_until(5, 1'b0);
        clear_counts();
        tb_wr_b = 1'b1; tb_db = 16'd8;
        tick();
        run_until(0, 1'b1);
        check(soc_seen == 0, "R6", "buffered B before zero", soc_seen, 0);
        clear_counts();
        run(2*P);
        check(soc_seen == 1, "R6", "buffered B after zero", soc_seen, 1);

        // R6: direct compare B write takes effect at once
        tb_shadow = 1'b0;
        run_until(5, 1'b0);
        clear_counts();
        tb_wr_b = 1'b1; tb_db = 16'd3;
        tick();
        run_until(0, 1'b1);
        check(soc_seen == 0, "R6", "direct B, match already passed", soc_seen, 0);

        // R8: second match in the same period is ignored
        run_until(5, 1'b0);
        clear_counts();
        tb_wr_b = 1'b1; tb_db = 16'd7;
        tick();
        run_until(0, 1'b1);
        check(soc_seen == 0, "R8", "second match same period", soc_seen, 0);
        clear_counts();
        run(2*P);
        check(soc_seen == 1, "R8", "next period fires again", soc_seen, 1);

        // R4: direct write of compare A
        run_until(5, 1'b0);
        tb_wr_a = 1'b1; tb_da = 16'd2;
        tick();
        check(mirror_a == 16'd2, "R4", "direct A next clock", mirror_a, 2);

        // R11: saturated compare A values
        tb_fed = 8'd0;
        tb_wr_a = 1'b1; tb_da = 16'd0;
        tick();
        clear_counts();
        run(2*P);
        check(hi_ones == 0, "R11", "A=0 high clocks", hi_ones, 0);
        check(lo_ones == 2*P, "R11", "A=0 low clocks", lo_ones, 2*P);
        tb_wr_a = 1'b1; tb_da = 16'(P + 1);
        tick();
        clear_counts();
        run(2*P);
        check(hi_ones == 2*P, "R11", "A>P high clocks", hi_ones, 2*P);

        run(2);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule